// File: doc/BRIEF.md
# Parallel Ramp-and-Count Converter Backend

This block is the digital side of a multi-channel ramp-compare converter. After a start strobe, one counter shared by every channel steps through a conversion window. Meanwhile an analog ramp outside this block rises past each channel's held level. Each channel watches its own comparator. In the first count cycle in which that comparator reads high, the channel stores the current count. It stores it minus that channel's pedestal, so the value is already corrected.

The correction is applied in the same clock as the capture. There is no separate correction pass after the window closes. A channel whose comparator fires before the count has passed its pedestal stores zero. A channel whose corrected value would exceed the result range, or whose comparator never fires, stores full scale. Pedestals are written one channel at a time through a small load port while the block is idle. When the window ends, a single-cycle done pulse marks the results as final. They then stay unchanged until the next conversion starts.

Top module: `wilkinson_backend`

## Requirements
- R1: After reset, `done_o` is 0, every result field is 0 and every pedestal is 0.
- R2: A start strobe sampled while idle begins a conversion. The shared count takes the values 0 to LAST, where LAST = (2^RW - 1) + (2^PW - 1), one per clock. If the start is sampled at edge E, `done_o` is high for exactly the one cycle that follows edge E+LAST+1 and is low in every other cycle.
- R3: If a channel's comparator is first sampled high while the count is k, that channel stores k minus its pedestal whenever 0 <= k - pedestal <= 2^RW - 1.
- R4: If k - pedestal is negative, the stored result is 0.
- R5: If k - pedestal exceeds 2^RW - 1, or the comparator is never sampled high during the window, the stored result is 2^RW - 1.
- R6: Only the first high comparator sample in a conversion is used. Later drops and re-rises of that comparator do not change the result.
- R7: A start strobe sampled during a conversion is ignored. The count and the done timing continue as if it were absent.
- R8: While no conversion runs, the result fields do not change, whatever the comparators do.
- R9: A pedestal write (`ped_we_i` high) while idle stores `ped_val_i` for channel `ped_sel_i`. A pedestal write during a conversion is ignored.
- R10: All channels convert in the same window from the same count, independently of one another. Channel c uses bits [c*RW +: RW] of `res_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Counter clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start-of-conversion strobe |
| cmp_i | input | NCH | Per-channel comparator outputs, high once the ramp has crossed the channel's level |
| ped_we_i | input | 1 | Pedestal write enable |
| ped_sel_i | input | max(1, clog2(NCH)) | Channel whose pedestal is written |
| ped_val_i | input | PW | Pedestal value to store |
| done_o | output | 1 | One-cycle pulse when results are final |
| res_o | output | NCH*RW | Corrected results, packed one channel per RW bits |

## Verification
The assertions take for granted that a comparator output is synchronous to the counter clock. They also take for granted that a pedestal-load request may arrive at any time, including during a conversion. The bench changes comparators and every other input only on the falling clock edge, so each level is settled before the rising edge that samples it. Comparators are held low before each start and are raised at chosen count values. The stimulus deliberately adds a second start strobe and a pedestal write partway through some conversions. It also adds comparator pulses that drop and rise again, so that the properties covering ignored requests and one-shot capture are exercised by input the design must reject.

// File: rtl/wk_pkg.sv
package wk_pkg;

  // Pedestal-corrected, range-limited value for a capture at raw count raw.
  function automatic int wk_correct(input int raw, input int ped, input int top);
    int diff;
    diff = raw - ped;
    if (diff < 0) return 0;
    if (diff > top) return top;
    return diff;
  endfunction

  function automatic int wk_last(input int rw, input int pw);
    return ((1 << rw) - 1) + ((1 << pw) - 1);
  endfunction

endpackage

// File: rtl/wk_count_ctrl.sv
module wk_count_ctrl #(
  parameter int LAST = 510,
  parameter int CW   = 9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  output logic          busy,
  output logic [CW-1:0] cnt,
  output logic          last,
  output logic          launch,
  output logic          done
);
  localparam logic [CW-1:0] LAST_V = CW'(LAST);

  assign launch = start && !busy;
  assign last   = busy && (cnt == LAST_V);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      cnt  <= '0;
      done <= 1'b0;
    end else begin
      done <= last;
      if (launch) begin
        busy <= 1'b1;
        cnt  <= '0;
      end else if (last) begin
        busy <= 1'b0;
      end else if (busy) begin
        cnt <= cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/wk_ped_bank.sv
module wk_ped_bank #(
  parameter int NCH = 128,
  parameter int PW  = 8,
  parameter int IW  = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              busy,
  input  logic              we,
  input  logic [IW-1:0]     sel,
  input  logic [PW-1:0]     val,
  output logic [NCH*PW-1:0] ped_flat
);
  for (genvar c = 0; c < NCH; c++) begin : g_ped
    logic wr_here;
    assign wr_here = we && !busy && (sel == IW'(c));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ped_flat[c*PW +: PW] <= '0;
      else if (wr_here) ped_flat[c*PW +: PW] <= val;
    end
  end
endmodule

// File: rtl/wk_channel.sv
module wk_channel
  import wk_pkg::*;
#(
  parameter int RW = 8,
  parameter int PW = 8,
  parameter int CW = 9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          launch,
  input  logic          busy,
  input  logic          last,
  input  logic          cmp,
  input  logic [CW-1:0] cnt,
  input  logic [PW-1:0] ped,
  output logic [RW-1:0] res,
  output logic          hit
);
  localparam int RMAX = (1 << RW) - 1;

  logic          fire;
  logic [RW-1:0] corr;

  assign fire = busy && !hit && cmp;
  assign corr = RW'(wk_correct(int'(cnt), int'(ped), RMAX));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hit <= 1'b0;
      res <= '0;
    end else if (launch) begin
      hit <= 1'b0;
    end else if (fire) begin
      hit <= 1'b1;
      res <= corr;
    end else if (last && !hit) begin
      res <= RW'(RMAX);
    end
  end
endmodule

// File: rtl/wilkinson_backend.sv
module wilkinson_backend
  import wk_pkg::*;
#(
  parameter int NCH = 128,
  parameter int RW  = 8,
  parameter int PW  = 8,
  localparam int IW   = (NCH > 1) ? $clog2(NCH) : 1,
  localparam int LAST = wk_last(RW, PW),
  localparam int CW   = $clog2(LAST + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [NCH-1:0]    cmp_i,
  input  logic              ped_we_i,
  input  logic [IW-1:0]     ped_sel_i,
  input  logic [PW-1:0]     ped_val_i,
  output logic              done_o,
  output logic [NCH*RW-1:0] res_o
);
  logic              busy_w;
  logic              last_w;
  logic              launch_w;
  logic [CW-1:0]     cnt_w;
  logic [NCH-1:0]    hit_w;
  logic [NCH*PW-1:0] ped_w;

  wk_count_ctrl #(.LAST(LAST), .CW(CW)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start_i), .busy(busy_w), .cnt(cnt_w),
    .last(last_w), .launch(launch_w), .done(done_o)
  );

  wk_ped_bank #(.NCH(NCH), .PW(PW), .IW(IW)) u_peds (
    .clk(clk), .rst_n(rst_n), .busy(busy_w), .we(ped_we_i), .sel(ped_sel_i),
    .val(ped_val_i), .ped_flat(ped_w)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    wk_channel #(.RW(RW), .PW(PW), .CW(CW)) u_ch (
      .clk(clk), .rst_n(rst_n), .launch(launch_w), .busy(busy_w), .last(last_w),
      .cmp(cmp_i[c]), .cnt(cnt_w), .ped(ped_w[c*PW +: PW]),
      .res(res_o[c*RW +: RW]), .hit(hit_w[c])
    );
  end
endmodule

// File: rtl/wk_backend_chk.sv
module wk_backend_chk #(
  parameter int NCH = 128,
  parameter int RW  = 8,
  parameter int PW  = 8,
  parameter int CW  = 9,
  parameter int LAST = 510
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic [CW-1:0]     cnt,
  input logic              done,
  input logic [NCH-1:0]    hit,
  input logic [NCH*RW-1:0] res,
  input logic [NCH*PW-1:0] ped
);
  // R2: done is a single-cycle pulse
  p_done_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R2: done only follows the end of a running window
  p_done_after_run_r2: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy)));

  // R7: a running window advances by one each cycle until its final count
  p_count_steps_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cnt != CW'(LAST)) |=> (busy && cnt == $past(cnt) + 1'b1));

  // R8: results hold while idle
  p_idle_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |=> $stable(res));

  // R9: pedestals frozen during a window
  p_ped_frozen_r9: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(ped));

  for (genvar c = 0; c < NCH; c++) begin : g_chk
    // R6: a captured channel keeps its result
    p_capture_once_r6: assert property (@(posedge clk) disable iff (!rst_n)
      hit[c] |=> $stable(res[c*RW +: RW]));
  end
endmodule

bind wilkinson_backend wk_backend_chk #(
  .NCH(NCH), .RW(RW), .PW(PW), .CW(CW), .LAST(LAST)
) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy_w), .cnt(cnt_w), .done(done_o),
  .hit(hit_w), .res(res_o), .ped(ped_w)
);

// File: tb/wilkinson_backend_test.sv
`timescale 1ns/1ps
module wilkinson_backend_test;
  localparam int NCH = 4;
  localparam int RW = 4;
  localparam int PW = 3;
  localparam int IW = 2;
  localparam int RMAX = (1 << RW) - 1;
  localparam int PMAX = (1 << PW) - 1;
  localparam int LAST = RMAX + PMAX;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_i = 1'b0;
  logic [NCH-1:0] cmp_i = '0;
  logic ped_we_i = 1'b0;
  logic [IW-1:0] ped_sel_i = '0;
  logic [PW-1:0] ped_val_i = '0;
  logic done_o;
  logic [NCH*RW-1:0] res_o;

  int checks = 0;
  int failures = 0;
  int ped_m [NCH];
  int fire [NCH];

  always #2 clk = ~clk;

  wilkinson_backend #(.NCH(NCH), .RW(RW), .PW(PW)) uut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .cmp_i(cmp_i),
    .ped_we_i(ped_we_i), .ped_sel_i(ped_sel_i), .ped_val_i(ped_val_i),
    .done_o(done_o), .res_o(res_o)
  );

  function automatic int expect_val(input int f, input int p);
    int v;
    if (f < 0) return RMAX;
    v = f - p;
    v = (v > RMAX) ? RMAX : v;
    return (v < 0) ? 0 : v;
  endfunction

  task automatic check(input string req, input int act, input int exp_v);
    checks++;
    if (act != exp_v) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp_v);
    end
  endtask

  task automatic write_ped(input int ch, input int v);
    ped_we_i = 1'b1; ped_sel_i = IW'(ch); ped_val_i = PW'(v);
    @(posedge clk); @(negedge clk);
    ped_we_i = 1'b0;
    ped_m[ch] = v;
  endtask

  // mode: 0 plain, 1 glitchy comparators, 2 restart + pedestal write mid-window
  task automatic run_conv(input int mode);
    int early_done;
    early_done = 0;
    start_i = 1'b1;
    @(posedge clk); @(negedge clk);
    start_i = 1'b0;
    for (int k = 0; k <= LAST; k++) begin
      for (int c = 0; c < NCH; c++) begin
        if (fire[c] < 0) cmp_i[c] = 1'b0;
        else if (mode == 1) cmp_i[c] = (k == fire[c]) || (k >= fire[c] + 3);
        else cmp_i[c] = (k >= fire[c]);
      end
      if (mode == 2 && k == 5) start_i = 1'b1;
      if (mode == 2 && k == 6) start_i = 1'b0;
      if (mode == 2 && k == 2) begin
        ped_we_i = 1'b1; ped_sel_i = '0; ped_val_i = PW'((ped_m[0] + 3) % (PMAX + 1));
      end
      if (mode == 2 && k == 3) ped_we_i = 1'b0;
      if (done_o) early_done++;
      @(posedge clk); @(negedge clk);
    end
    check(mode == 2 ? "R7 done held off" : "R2 no early done", early_done, 0);
    check(mode == 2 ? "R7 done timing" : "R2 done pulse", int'(done_o), 1);
    cmp_i = '0;
    for (int c = 0; c < NCH; c++) begin
      int e;
      string tag;
      e = expect_val(fire[c], ped_m[c]);
      if (fire[c] < 0) tag = "R5 never fired";
      else if (fire[c] - ped_m[c] < 0) tag = "R4 below pedestal";
      else if (fire[c] - ped_m[c] > RMAX) tag = "R5 clamp";
      else if (mode == 1) tag = "R6 first edge";
      else if (mode == 2) tag = "R9 pedestal frozen";
      else tag = "R3 corrected count";
      check(tag, int'(res_o[c*RW +: RW]), e);
    end
    @(posedge clk); @(negedge clk);
    check("R2 done width", int'(done_o), 0);
  endtask

  initial begin
    #(4 * 200000);
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [NCH*RW-1:0] snap;
    for (int c = 0; c < NCH; c++) ped_m[c] = 0;
    repeat (3) @(negedge clk);
    check("R1 done at reset", int'(done_o), 0);
    check("R1 results at reset", int'(res_o), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: pedestals start at zero, seen through a plain conversion
    for (int c = 0; c < NCH; c++) fire[c] = 2 + c;
    run_conv(0);

    // R3 R4 R5 R10: sweep fire points and pedestals across channels
    for (int p = 0; p < LAST + 2; p++) begin
      for (int c = 0; c < NCH; c++) begin
        write_ped(c, (p + 2 * c) % (PMAX + 1));
        fire[c] = ((p + 5 * c) % (LAST + 2)) - 1;
      end
      run_conv(0);
    end

    // R8: idle comparator activity leaves results alone
    snap = res_o;
    for (int i = 0; i < 8; i++) begin
      cmp_i = NCH'(i * 5 + 1);
      @(posedge clk); @(negedge clk);
    end
    cmp_i = '0;
    check("R8 idle hold", int'(res_o), int'(snap));

    // R6: glitchy comparators
    for (int c = 0; c < NCH; c++) begin
      write_ped(c, c + 1);
      fire[c] = 4 + 3 * c;
    end
    run_conv(1);

    // R7 R9: restart and pedestal write mid-window, then confirm old pedestal
    run_conv(2);
    run_conv(0);

    // R9: idle write to an out-of-order channel takes effect
    write_ped(2, PMAX);
    fire[2] = 10;
    run_conv(0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule